// File: doc/BRIEF.md
# Masked Sticky Alarm Status Register

This block collects alarm events from a battery-protection monitor into one 16-bit word of sticky flags. Each event source owns one fixed bit position, or two in one case. When the source fires, its flag is set and stays set. It stays set after the source goes quiet, until software clears it by writing a one to that position. Software sees the word on a read-data output. A separate open-drain style alert output is held low while any flag is set.

Sources come in several kinds:

- Level sources, which are gated by a 16-bit mask input. This covers the four protection summaries and the two driver-off levels.
- Qualified pulse sources, which are also mask-gated. This covers the check-interval completion, which must occur in NORMAL mode, and the init-complete pulse.
- Ungated sources, which latch whenever they fire. These are the shutdown undervoltage flag (cell or stack), the charger-detector change flag and the power-on-reset status flag.

The charger-detector flag fires on any change of the debounced detector level relative to the value sampled on the previous clock. The block stores that previous level itself.

All inputs are synchronous to `clk` and are sampled on the rising edge. A flag set or cleared at an edge is visible on `rd_data` and `alert_n` directly after that edge. The asynchronous reset is released through an internal synchronizer, so the block leaves reset `SYNC_STAGES` clocks after `rst_n` rises.

Top module: `alm_status_top`

## Requirements
- R1: After reset, `rd_data` is 16'h0000 and `alert_n` is 1, and a charger-detector level that is already high at reset release does not set bit 1.
- R2: Bits 8, 5, 4 and 3 always read 0, and writing ones to them has no effect.
- R3: Bits 15, 14, 13 and 12 latch from `prot_sum[3]`, `prot_sum[2]`, `prot_sum[1]` and `prot_sum[0]`. Bits 11 and 10 latch from `chg_off` and `dsg_off`. Each of these bits sets only in a cycle where its source is 1 and `mask` at the same bit position is 1.
- R4: Bit 9 sets whenever `uv_cell` or `uv_stack` is 1, regardless of `mask`.
- R5: Bits 7 and 6 both set in a cycle where `chk_done`, `in_normal` and the `mask` bit at their own position are all 1. A `chk_done` outside NORMAL mode sets neither.
- R6: Bit 2 sets when `init_done` is 1 and `mask[2]` is 1.
- R7: Bit 1 sets when `chgdet` differs from its value on the previous clock, in either direction, regardless of `mask`. An unchanged level never sets it.
- R8: Bit 0 sets whenever `por_stat` is 1, regardless of `mask`.
- R9: A set flag stays set after its source returns to 0, until it is cleared by a write.
- R10: A cycle with `wr_en` = 1 clears every flag whose `wr_data` bit is 1. Flags whose `wr_data` bit is 0 keep their value.
- R11: When a set condition and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R12: `alert_n` is 0 exactly when `rd_data` is nonzero, and it changes in the same cycle as `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prot_sum | input | 4 | Protection summary levels for bits 15..12 |
| chg_off | input | 1 | Charge driver disabled level |
| dsg_off | input | 1 | Discharge driver disabled level |
| uv_cell | input | 1 | Cell voltage below shutdown threshold |
| uv_stack | input | 1 | Stack voltage below shutdown threshold |
| chk_done | input | 1 | One-cycle pulse: check interval finished |
| in_normal | input | 1 | Device is in NORMAL mode |
| init_done | input | 1 | One-cycle pulse: first protection evaluation finished |
| chgdet | input | 1 | Debounced charger-detector level |
| por_stat | input | 1 | Power-on-reset status flag |
| mask | input | 16 | Per-bit latch enable for gated sources |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data; ones clear flags |
| rd_data | output | 16 | Latched flag word |
| alert_n | output | 1 | Low while any flag is set |

## Verification
A wrong flag register shows up on `rd_data` and `alert_n` on the very next clock. Examples are a flag that drops without a write, a gated source that ignores its mask bit, or a clear that beats a simultaneous set. A stale or wrongly initialised stored charger-detector level has different symptoms. It either produces a bit-1 flag right after reset, or misses a flag one clock after the detector level changes. The bench therefore reads the word one clock after every stimulus and again after each clearing write.

// File: rtl/alm_pkg.sv
package alm_pkg;
  localparam int DW = 16;

  localparam int B_FLT_A  = 15;
  localparam int B_FLT_B  = 14;
  localparam int B_WRN_A  = 13;
  localparam int B_WRN_B  = 12;
  localparam int B_CHGOFF = 11;
  localparam int B_DSGOFF = 10;
  localparam int B_SHUTUV = 9;
  localparam int B_CHK_HI = 7;
  localparam int B_CHK_LO = 6;
  localparam int B_INIT   = 2;
  localparam int B_DETCHG = 1;
  localparam int B_PORST  = 0;

  // positions that never hold a flag
  localparam logic [DW-1:0] RSVD_BITS  = 16'h0138;
  // positions whose set path goes through the mask
  localparam logic [DW-1:0] GATED_BITS = 16'hFCC4;
endpackage

// File: rtl/alm_rst_sync.sv
module alm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_q_n = chain_q[STAGES-1];
endmodule

// File: rtl/alm_src_cond.sv
module alm_src_cond
  import alm_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    prot_sum,
  input  logic          chg_off,
  input  logic          dsg_off,
  input  logic          uv_cell,
  input  logic          uv_stack,
  input  logic          chk_done,
  input  logic          in_normal,
  input  logic          init_done,
  input  logic          chgdet,
  input  logic          por_stat,
  input  logic [DW-1:0] mask,
  output logic [DW-1:0] set_vec
);
  // stored previous detector level and a flag telling it is valid
  logic det_prev_q, det_prev_d;
  logic det_vld_q, det_vld_d;
  logic det_edge;
  logic [DW-1:0] raw_vec;
  logic [DW-1:0] gate_vec;

  always_comb begin
    det_prev_d = chgdet;
    det_vld_d  = 1'b1;
    det_edge   = det_vld_q && (chgdet != det_prev_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      det_prev_q <= 1'b0;
      det_vld_q  <= 1'b0;
    end else begin
      det_prev_q <= det_prev_d;
      det_vld_q  <= det_vld_d;
    end
  end

  always_comb begin
    raw_vec           = '0;
    raw_vec[B_FLT_A]  = prot_sum[3];
    raw_vec[B_FLT_B]  = prot_sum[2];
    raw_vec[B_WRN_A]  = prot_sum[1];
    raw_vec[B_WRN_B]  = prot_sum[0];
    raw_vec[B_CHGOFF] = chg_off;
    raw_vec[B_DSGOFF] = dsg_off;
    raw_vec[B_SHUTUV] = uv_cell | uv_stack;
    raw_vec[B_CHK_HI] = chk_done & in_normal;
    raw_vec[B_CHK_LO] = chk_done & in_normal;
    raw_vec[B_INIT]   = init_done;
    raw_vec[B_DETCHG] = det_edge;
    raw_vec[B_PORST]  = por_stat;
  end

  always_comb begin
    gate_vec = mask | ~GATED_BITS;
    set_vec  = raw_vec & gate_vec & ~RSVD_BITS;
  end
endmodule

// File: rtl/alm_sticky_bank.sv
module alm_sticky_bank #(
  parameter int              WIDTH = 16,
  parameter logic [WIDTH-1:0] HOLES = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] flag_q,
  output logic [WIDTH-1:0] flag_nxt
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (HOLES[i]) begin : g_hole
      logic unused_bit;
      assign unused_bit  = set_i[i] ^ clr_i[i];
      assign flag_q[i]   = 1'b0;
      assign flag_nxt[i] = 1'b0;
    end else begin : g_flop
      logic bit_q, bit_d, bit_en;
      always_comb begin
        bit_en = set_i[i] | clr_i[i];
        // set has priority over clear
        bit_d  = set_i[i] | (bit_q & ~clr_i[i]);
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bit_q <= 1'b0;
        else if (bit_en) bit_q <= bit_d;
      end
      assign flag_q[i]   = bit_q;
      assign flag_nxt[i] = bit_en ? bit_d : bit_q;
    end
  end
endmodule

// File: rtl/alm_alert_drv.sv
module alm_alert_drv #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] flag_nxt,
  output logic             alert_n
);
  logic alert_n_q, alert_n_d;

  always_comb alert_n_d = ~(|flag_nxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alert_n_q <= 1'b1;
    else        alert_n_q <= alert_n_d;
  end

  assign alert_n = alert_n_q;
endmodule

// File: rtl/alm_status_top.sv
module alm_status_top
  import alm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    prot_sum,
  input  logic          chg_off,
  input  logic          dsg_off,
  input  logic          uv_cell,
  input  logic          uv_stack,
  input  logic          chk_done,
  input  logic          in_normal,
  input  logic          init_done,
  input  logic          chgdet,
  input  logic          por_stat,
  input  logic [DW-1:0] mask,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          alert_n
);
  logic          rst_q_n;
  logic [DW-1:0] set_vec;
  logic [DW-1:0] clr_vec;
  logic [DW-1:0] flag_q;
  logic [DW-1:0] flag_nxt;

  alm_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n)
  );

  alm_src_cond u_src (
    .clk(clk), .rst_n(rst_q_n), .prot_sum(prot_sum), .chg_off(chg_off),
    .dsg_off(dsg_off), .uv_cell(uv_cell), .uv_stack(uv_stack),
    .chk_done(chk_done), .in_normal(in_normal), .init_done(init_done),
    .chgdet(chgdet), .por_stat(por_stat), .mask(mask), .set_vec(set_vec)
  );

  always_comb clr_vec = wr_en ? (wr_data & ~RSVD_BITS) : '0;

  alm_sticky_bank #(.WIDTH(DW), .HOLES(RSVD_BITS)) u_bank (
    .clk(clk), .rst_n(rst_q_n), .set_i(set_vec), .clr_i(clr_vec),
    .flag_q(flag_q), .flag_nxt(flag_nxt)
  );

  alm_alert_drv #(.WIDTH(DW)) u_alert (
    .clk(clk), .rst_n(rst_q_n), .flag_nxt(flag_nxt), .alert_n(alert_n)
  );

  assign rd_data = flag_q;
endmodule

// File: rtl/alm_status_chk.sv
module alm_status_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  prot_sum,
  input logic        uv_cell,
  input logic        uv_stack,
  input logic        chk_done,
  input logic        in_normal,
  input logic        por_stat,
  input logic [15:0] mask,
  input logic        wr_en,
  input logic [15:0] wr_data,
  input logic [15:0] rd_data,
  input logic        alert_n
);
  logic [15:0] keep_v;
  assign keep_v = rd_data & ~(wr_en ? wr_data : 16'h0000);

  assert_alert_match_R12: assert property (@(posedge clk) disable iff (!rst_n)
    alert_n == (rd_data == 16'h0000));

  assert_gated_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_sum[3] && mask[15]) |=> rd_data[15]);

  assert_gated_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!(prot_sum[3] && mask[15]) && wr_en && wr_data[15]) |=> !rd_data[15]);

  assert_shutuv_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_cell || uv_stack) |=> rd_data[9]);

  assert_chk_qual_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!(chk_done && in_normal) && !rd_data[7]) |=> !rd_data[7]);

  assert_por_setwin_R8: assert property (@(posedge clk) disable iff (!rst_n)
    por_stat |=> rd_data[0]);

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((rd_data & $past(keep_v)) == $past(keep_v)));
endmodule

bind alm_status_top alm_status_chk u_chk (
  .clk(clk), .rst_n(rst_q_n), .prot_sum(prot_sum), .uv_cell(uv_cell),
  .uv_stack(uv_stack), .chk_done(chk_done), .in_normal(in_normal),
  .por_stat(por_stat), .mask(mask), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .alert_n(alert_n)
);

// File: tb/tb_alm_status_top.sv
`timescale 1ns/1ps
module tb_alm_status_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  prot_sum;
  logic        chg_off, dsg_off, uv_cell, uv_stack;
  logic        chk_done, in_normal, init_done, chgdet, por_stat;
  logic [15:0] mask;
  logic        wr_en;
  logic [15:0] wr_data;
  logic [15:0] rd_data;
  logic        alert_n;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  alm_status_top dut (
    .clk(clk), .rst_n(rst_n), .prot_sum(prot_sum), .chg_off(chg_off),
    .dsg_off(dsg_off), .uv_cell(uv_cell), .uv_stack(uv_stack),
    .chk_done(chk_done), .in_normal(in_normal), .init_done(init_done),
    .chgdet(chgdet), .por_stat(por_stat), .mask(mask), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .alert_n(alert_n)
  );

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic quiet();
    prot_sum = '0; chg_off = 0; dsg_off = 0; uv_cell = 0; uv_stack = 0;
    chk_done = 0; init_done = 0; por_stat = 0; wr_en = 0; wr_data = '0;
  endtask

  task automatic wipe();
    quiet();
    wr_en = 1; wr_data = 16'hFFFF;
    step();
    wr_en = 0; wr_data = '0;
  endtask

  task automatic do_reset(input logic det_lvl);
    quiet();
    in_normal = 0; chgdet = det_lvl; mask = '0;
    rst_n = 0;
    repeat (3) step();
    rst_n = 1;
    repeat (5) step();
  endtask

  task automatic t_reset();
    do_reset(1'b0);
    chk("R1", "rd_data after reset", rd_data, 16'h0000);
    chk("R1", "alert_n after reset", {15'd0, alert_n}, 16'h0001);
    do_reset(1'b1);
    step();
    chk("R1", "no detector flag for high level at release", rd_data, 16'h0000);
  endtask

  task automatic t_masked();
    wipe();
    mask = 16'h0000;
    prot_sum = 4'hF; chg_off = 1; dsg_off = 1;
    step();
    chk("R3", "masked-off gated sources", rd_data, 16'h0000);
    mask = 16'hA800;
    step();
    chk("R3", "partial mask 15,13,11", rd_data, 16'hA800);
    mask = 16'hFFFF;
    step();
    chk("R3", "full mask gated bits", rd_data, 16'hFC00);
    quiet();
    step();
    chk("R9", "flags held after sources drop", rd_data, 16'hFC00);
    wipe();
  endtask

  task automatic t_shutuv();
    mask = 16'h0000;
    uv_cell = 1;
    step();
    chk("R4", "cell undervoltage ignores mask", rd_data, 16'h0200);
    quiet(); wipe();
    uv_stack = 1;
    step();
    chk("R4", "stack undervoltage", rd_data, 16'h0200);
    quiet(); wipe();
  endtask

  task automatic t_check();
    mask = 16'hFFFF;
    in_normal = 0; chk_done = 1;
    step();
    chk_done = 0;
    chk("R5", "check pulse outside NORMAL", rd_data, 16'h0000);
    in_normal = 1; chk_done = 1;
    step();
    chk_done = 0;
    chk("R5", "check pulse in NORMAL", rd_data, 16'h00C0);
    wipe();
    mask = 16'h0080; chk_done = 1;
    step();
    chk_done = 0;
    chk("R5", "check with only bit 7 mask", rd_data, 16'h0080);
    wipe();
    in_normal = 0;
  endtask

  task automatic t_init();
    mask = 16'h0000; init_done = 1;
    step();
    init_done = 0;
    chk("R6", "init pulse masked off", rd_data, 16'h0000);
    mask = 16'h0004; init_done = 1;
    step();
    init_done = 0;
    chk("R6", "init pulse masked on", rd_data, 16'h0004);
    wipe();
  endtask

  task automatic t_toggle();
    mask = 16'h0000;
    chgdet = 0;
    step(); wipe();
    chgdet = 1;
    step();
    chk("R7", "detector rise", rd_data, 16'h0002);
    wipe();
    step();
    chk("R7", "steady high level", rd_data, 16'h0000);
    chgdet = 0;
    step();
    chk("R7", "detector fall", rd_data, 16'h0002);
    wipe();
  endtask

  task automatic t_por();
    mask = 16'h0000; por_stat = 1;
    step();
    por_stat = 0;
    chk("R8", "power-on status", rd_data, 16'h0001);
    wipe();
  endtask

  task automatic t_clear();
    mask = 16'hFFFF; prot_sum = 4'hF; por_stat = 1;
    step();
    quiet();
    step();
    chk("R9", "held set", rd_data, 16'hF001);
    wr_en = 1; wr_data = 16'h5000;
    step();
    wr_en = 0;
    chk("R10", "clear bits 14,12 only", rd_data, 16'hA001);
    chk("R12", "alert low while flags remain", {15'd0, alert_n}, 16'h0000);
    wr_en = 1; wr_data = 16'h0000;
    step();
    wr_en = 0;
    chk("R10", "write of zeros changes nothing", rd_data, 16'hA001);
    wr_en = 1; wr_data = 16'hA001;
    step();
    wr_en = 0;
    chk("R10", "clear rest", rd_data, 16'h0000);
    chk("R12", "alert high when empty", {15'd0, alert_n}, 16'h0001);
  endtask

  task automatic t_collide();
    mask = 16'h0000;
    por_stat = 1; wr_en = 1; wr_data = 16'h0001;
    step();
    quiet();
    chk("R11", "set beats clear on bit 0", rd_data, 16'h0001);
    mask = 16'h8000; prot_sum = 4'h8;
    step();
    mask = 16'h0000; wr_en = 1; wr_data = 16'h8001;
    step();
    quiet();
    chk("R3", "mask off lets clear win on bit 15", rd_data, 16'h0000);
  endtask

  task automatic t_reserved();
    mask = 16'hFFFF; in_normal = 1;
    prot_sum = 4'hF; chg_off = 1; dsg_off = 1; uv_cell = 1;
    chk_done = 1; init_done = 1; por_stat = 1; chgdet = ~chgdet;
    step();
    quiet();
    chk("R2", "all sources, holes stay 0", rd_data, 16'hFEC7);
    chk("R12", "alert with all flags", {15'd0, alert_n}, 16'h0000);
    wr_en = 1; wr_data = 16'h0138;
    step();
    wr_en = 0;
    chk("R2", "write to holes leaves flags", rd_data, 16'hFEC7);
    wipe();
    in_normal = 0;
    chk("R12", "alert released after clear", {15'd0, alert_n}, 16'h0001);
  endtask

  initial begin
    while (cyc < 100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0;
    t_reset();
    t_masked();
    t_shutuv();
    t_check();
    t_init();
    t_toggle();
    t_por();
    t_clear();
    t_collide();
    t_reserved();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule